// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor-side request port and a word-wide memory port. Each request carries a byte address, a write flag and write data. The address is divided into a word-within-block field, a set index and a tag. Both ways of the chosen set are compared at the same time. A hit completes in the cycle it is presented. A read returns its word combinationally in that same cycle.

On a miss the controller picks a victim. An empty way is preferred. When both ways are full, the single least-recently-used bit of the set makes the choice. A dirty victim is streamed out word by word before the new block is streamed in. Once the block is present, the held request is completed. Writes always allocate, and they change memory only when a dirty block is evicted.

Top module: `sa2_cache`

## Requirements
- R1: Field split for 4-byte words: word-in-block = (addr/4) mod BLK_WORDS, block number = addr/(4*BLK_WORDS), set = block mod SETS, tag = block / SETS. Memory transfers carry the byte address of each word, so block B word w is at (B*BLK_WORDS+w)*4.
- R2: A request whose block is resident sees req_ready high in the same cycle it is presented. For a read, the word is on req_rdata in that cycle. No memory transfer takes place.
- R3: Reset clears every valid bit, so the first access to any block misses. After reset, with no request pending, req_ready and mem_valid are low.
- R4: On a miss in a set with an invalid way, the block goes into way 0 if way 0 is invalid, and otherwise into way 1.
- R5: On a miss in a set with both ways valid, the least recently used way is replaced.
- R6: Every accepted access, read or write, makes the way it touched the most recently used one.
- R7: A write hit changes only the cache and marks the block dirty. A dirty victim is written to memory, all of its words in ascending order, before any refill read of the new block.
- R8: A clean victim is dropped without any memory write.
- R9: A write miss first refills the whole block from memory and then merges the written word. The other words of the block keep their memory values.
- R10: Each memory word transfer completes in a cycle where mem_valid and mem_ready are both high. While mem_ready is low, mem_valid, mem_we and mem_addr stay unchanged. req_ready stays low from the miss until the block is refilled, then rises for one cycle that completes the held request. req_ready and mem_valid are never high together.
- R11: With 2 sets, the block sequence 0,2,0,1,4,0,2,3,5,4 gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor request present; must be held until accepted |
| req_ready | output | 1 | Request accepted at this clock edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | DATA_W | Write word |
| req_rdata | output | DATA_W | Read word, valid while req_valid and req_ready are high |
| mem_valid | output | 1 | Memory word transfer requested |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | ADDR_W | Byte address of the word transferred |
| mem_wdata | output | DATA_W | Write-back word |
| mem_rdata | input | DATA_W | Refill word, sampled when mem_valid and mem_ready are high |

## Verification
The hardest case to reach is a dirty victim chosen by the LRU bit rather than by an empty way. It needs a set that is full, has a write hit on one way, and then has that way become the older of the two. Directed sequences build exactly this history: a write hit, an access to the other way, then a miss to a third block of the same set. After that, reads are issued whose results depend on the written-back data coming back from memory. A long pseudo-random run confined to a dozen blocks then keeps sets full and mixes dirty and clean evictions. The memory side stalls for a varying number of cycles throughout this run.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/sa2_rst_sync.sv
module sa2_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q    <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      meta_q    <= 1'b1;
      rst_out_n <= meta_q;
    end
  end
endmodule

// File: rtl/sa2_tag_match.sv
module sa2_tag_match #(
  parameter int TAG_W = 8,
  parameter int NWAYS = 2
) (
  input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [NWAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [NWAYS-1:0]            hit_vec
);
  for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_vld[g] && (way_tag[g] == look_tag);
  end
endmodule

// File: rtl/sa2_victim_pick.sv
module sa2_victim_pick (
  input  logic [1:0] way_vld,
  input  logic       lru_way,
  output logic       victim
);
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = lru_way;
  end
endmodule

// File: rtl/sa2_block_store.sv
module sa2_block_store #(
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4,
  parameter int SET_W     = 3,
  parameter int WSEL_W    = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [SETS][2][BLK_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_set][wr_way][wr_word] <= wr_data;
  end

  assign rd_data = word_q[rd_set][rd_way][rd_word];
endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import sa2_cache_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETS      = 8,
  parameter int BLK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W    = $clog2(DATA_W / 8);
  localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WSEL_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int TAG_W     = ADDR_W - BYTE_W - $clog2(BLK_WORDS) - $clog2(SETS);
  localparam int LAST_WORD = BLK_WORDS - 1;

  logic rst_i_n;
  sa2_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_out_n(rst_i_n));

  // address fields
  logic [ADDR_W-1:0] word_addr, blk_num;
  logic [WSEL_W-1:0] word_sel;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  assign word_addr = req_addr >> BYTE_W;
  assign blk_num   = word_addr / ADDR_W'(BLK_WORDS);
  assign word_sel  = WSEL_W'(word_addr % ADDR_W'(BLK_WORDS));
  assign set_idx   = SET_W'(blk_num % ADDR_W'(SETS));
  assign req_tag   = TAG_W'(blk_num / ADDR_W'(SETS));

  // state
  ctl_state_e        state_q, state_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic              vict_q, vict_d;
  logic [1:0]        valid_q [SETS];
  logic [1:0]        dirty_q [SETS];
  logic [1:0][TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]   lru_q;

  // lookup
  logic [1:0] hit_vec;
  logic       hit, hit_way, victim;
  sa2_tag_match #(.TAG_W(TAG_W), .NWAYS(2)) u_match (
    .way_tag(tag_q[set_idx]), .way_vld(valid_q[set_idx]),
    .look_tag(req_tag), .hit_vec(hit_vec)
  );
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  sa2_victim_pick u_pick (
    .way_vld(valid_q[set_idx]), .lru_way(lru_q[set_idx]), .victim(victim)
  );

  logic accept, wr_hit, fill_xfer, last_word, fill_done;
  assign req_ready = hit && (state_q == ST_IDLE || state_q == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign wr_hit    = accept && req_we;
  assign last_word = (cnt_q == WSEL_W'(LAST_WORD));
  assign fill_xfer = (state_q == ST_FILL) && mem_ready;
  assign fill_done = fill_xfer && last_word;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    vict_d  = vict_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !hit) begin
          vict_d = victim;
          cnt_d  = '0;
          state_d = (valid_q[set_idx][victim] && dirty_q[set_idx][victim])
                    ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        if (mem_ready) begin
          if (last_word) begin
            cnt_d   = '0;
            state_d = ST_FILL;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (mem_ready) begin
          if (last_word) state_d = ST_RESP;
          else           cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vict_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vict_q  <= vict_d;
    end
  end

  // line status
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      lru_q <= '0;
    end else begin
      if (fill_done) begin
        valid_q[set_idx][vict_q] <= 1'b1;
        dirty_q[set_idx][vict_q] <= 1'b0;
      end
      if (wr_hit) dirty_q[set_idx][hit_way] <= 1'b1;
      if (accept) lru_q[set_idx] <= ~hit_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[set_idx][vict_q] <= req_tag;
  end

  // data array
  logic              rd_way;
  logic [WSEL_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_data;
  assign rd_way  = (state_q == ST_WBACK) ? vict_q : hit_way;
  assign rd_word = (state_q == ST_WBACK) ? cnt_q  : word_sel;

  sa2_block_store #(
    .DATA_W(DATA_W), .SETS(SETS), .BLK_WORDS(BLK_WORDS),
    .SET_W(SET_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk(clk),
    .wr_en(fill_xfer || wr_hit),
    .wr_set(set_idx),
    .wr_way(fill_xfer ? vict_q : hit_way),
    .wr_word(fill_xfer ? cnt_q : word_sel),
    .wr_data(fill_xfer ? mem_rdata : req_wdata),
    .rd_set(set_idx), .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data)
  );

  // memory side
  logic [TAG_W-1:0]  mem_tag;
  logic [ADDR_W-1:0] mem_blk;
  assign mem_tag   = (state_q == ST_WBACK) ? tag_q[set_idx][vict_q] : req_tag;
  assign mem_blk   = ADDR_W'(mem_tag) * ADDR_W'(SETS) + ADDR_W'(set_idx);
  assign mem_addr  = (mem_blk * ADDR_W'(BLK_WORDS) + ADDR_W'(cnt_q)) << BYTE_W;
  assign mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_wdata = rd_data;
  assign req_rdata = rd_data;
endmodule

// File: rtl/sa2_cache_chk.sv
module sa2_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8,
  parameter int SET_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SETS-1:0]   lru_q,
  input logic [SET_W-1:0]  set_idx,
  input logic              hit_way
);
  // R10
  ready_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_valid));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R7
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> !(mem_valid && mem_we));

  // R6
  mru_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (lru_q[$past(set_idx)] != $past(hit_way)));
endmodule

bind sa2_cache sa2_cache_chk #(.ADDR_W(ADDR_W), .SETS(SETS), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .lru_q(lru_q), .set_idx(set_idx), .hit_way(hit_way)
);

// File: tb/sa2_cache_bench.sv
module sa2_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NS = 2;
  localparam int BW = 2;
  localparam int MEMW = 256;

  logic clk, rst_n;
  logic req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, req_rdata;
  logic mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  sa2_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .BLK_WORDS(BW)) u_sa2_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int xfers = 0, wr_x = 0, dly = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 + 32'(i * 37);
  endfunction

  // reference model
  logic [31:0] bmem [MEMW];
  logic [31:0] ref_mem [MEMW];
  bit m_vld [NS][2];
  bit m_dty [NS][2];
  int m_tag [NS][2];
  int m_lru [NS];
  logic [31:0] m_dat [NS][2][BW];
  bit q_we[$];
  int q_addr[$];
  logic [31:0] q_data[$];

  task automatic model_step(input bit we, input int addr, input logic [31:0] wd,
                            output bit hit, output logic [31:0] rd);
    int wa, blk, w, s, t, way;
    wa = addr / 4; blk = wa / BW; w = wa % BW; s = blk % NS; t = blk / NS;
    way = -1;
    for (int k = 0; k < 2; k++)
      if (m_vld[s][k] && m_tag[s][k] == t) way = k;
    hit = (way >= 0);
    if (!hit) begin
      if (!m_vld[s][0]) way = 0;
      else if (!m_vld[s][1]) way = 1;
      else way = m_lru[s];
      if (m_vld[s][way] && m_dty[s][way]) begin
        for (int i = 0; i < BW; i++) begin
          int a;
          a = (m_tag[s][way] * NS + s) * BW + i;
          q_we.push_back(1'b1); q_addr.push_back(a * 4); q_data.push_back(m_dat[s][way][i]);
          ref_mem[a] = m_dat[s][way][i];
        end
      end
      for (int i = 0; i < BW; i++) begin
        int a;
        a = (t * NS + s) * BW + i;
        q_we.push_back(1'b0); q_addr.push_back(a * 4); q_data.push_back('0);
        m_dat[s][way][i] = ref_mem[a];
      end
      m_vld[s][way] = 1'b1; m_dty[s][way] = 1'b0; m_tag[s][way] = t;
    end
    rd = m_dat[s][way][w];
    if (we) begin
      m_dat[s][way][w] = wd;
      m_dty[s][way] = 1'b1;
    end
    m_lru[s] = 1 - way;
  endtask

  // memory responder: decides and records each transfer at the negative edge
  always @(negedge clk) begin
    if (rst_n && mem_valid && dly == 0) begin
      mem_ready = 1'b1;
      mem_rdata = bmem[mem_addr[AW-1:2]];
      if (q_we.size() == 0) begin
        chk(1'b0, "R10", "unexpected memory transfer", longint'(mem_addr), 0);
      end else begin
        bit e_we; int e_a; logic [31:0] e_d;
        e_we = q_we.pop_front(); e_a = q_addr.pop_front(); e_d = q_data.pop_front();
        chk(mem_we == e_we, "R7", "transfer direction", longint'(mem_we), longint'(e_we));
        chk(int'(mem_addr) == e_a, "R1", "transfer address", longint'(mem_addr), longint'(e_a));
        if (mem_we) begin
          chk(mem_wdata == e_d, "R7", "write-back data", longint'(mem_wdata), longint'(e_d));
          bmem[mem_addr[AW-1:2]] = mem_wdata;
        end
      end
      if (mem_we) wr_x++;
      xfers++;
      dly = xfers % 3;
    end else begin
      mem_ready = 1'b0;
      if (rst_n && mem_valid && dly > 0) dly--;
    end
    if (rst_n && req_ready && mem_valid)
      chk(1'b0, "R10", "ready during memory traffic", 1, 0);
  end

  task automatic do_acc(input bit we, input int addr, input logic [31:0] wd,
                        input string rq, output bit hit_o, output logic [31:0] rd_o);
    bit e_hit; logic [31:0] e_rd; int n;
    model_step(we, addr, wd, e_hit, e_rd);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
    #1;
    n = 0;
    while (!req_ready && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    rd_o = req_rdata;
    hit_o = (n == 0);
    chk(n < 1000, rq, "request never accepted", n, 0);
    chk(hit_o == e_hit, rq, "hit flag", longint'(hit_o), longint'(e_hit));
    if (!we) chk(rd_o == e_rd, rq, "read data", longint'(rd_o), longint'(e_rd));
    @(negedge clk);
    req_valid = 1'b0;
    chk(q_we.size() == 0, rq, "pending memory transfers", q_we.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    bit h; logic [31:0] r; int wx0, x0; int seq [10]; bit pat_hit [10];
    int lcg;
    seq = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    pat_hit = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    for (int i = 0; i < MEMW; i++) begin bmem[i] = pat(i); ref_mem[i] = pat(i); end
    for (int s = 0; s < NS; s++) begin
      m_lru[s] = 0;
      for (int k = 0; k < 2; k++) begin m_vld[s][k] = 0; m_dty[s][k] = 0; m_tag[s][k] = 0; end
    end
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    mem_ready = 0; mem_rdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R3: idle after reset
    chk(!req_ready, "R3", "req_ready after reset", longint'(req_ready), 0);
    chk(!mem_valid, "R3", "mem_valid after reset", longint'(mem_valid), 0);
    @(negedge clk);

    // R11 / R4 / R5: replacement sequence on block numbers
    for (int i = 0; i < 10; i++) begin
      do_acc(1'b0, seq[i] * BW * 4, '0, "R11", h, r);
      chk(h == pat_hit[i], "R11", "sequence hit pattern", longint'(h), longint'(pat_hit[i]));
    end
    chk(r == pat(8), "R4", "block 4 word 0 data", longint'(r), longint'(pat(8)));

    // R7: write hit stays in cache
    x0 = xfers;
    do_acc(1'b1, 4 * BW * 4 + 4, 32'hDEAD_BEEF, "R7", h, r);
    chk(h, "R2", "write to resident block hits", longint'(h), 1);
    chk(xfers == x0, "R7", "write hit memory traffic", xfers - x0, 0);
    do_acc(1'b0, 4 * BW * 4 + 4, '0, "R2", h, r);
    chk(r == 32'hDEAD_BEEF, "R2", "read-back after write hit", longint'(r), 32'hDEAD_BEEF);

    // R8: clean victim (block 2) dropped
    wx0 = wr_x;
    do_acc(1'b0, 6 * BW * 4, '0, "R8", h, r);
    chk(wr_x == wx0, "R8", "writes on clean eviction", wr_x - wx0, 0);

    // R5 / R7: LRU victim is dirty block 4
    wx0 = wr_x;
    do_acc(1'b0, 8 * BW * 4, '0, "R5", h, r);
    chk(wr_x - wx0 == BW, "R7", "dirty eviction write count", wr_x - wx0, BW);
    chk(bmem[4 * BW + 1] == 32'hDEAD_BEEF, "R7", "memory after write-back",
        longint'(bmem[4 * BW + 1]), 32'hDEAD_BEEF);
    do_acc(1'b0, 4 * BW * 4 + 4, '0, "R7", h, r);
    chk(r == 32'hDEAD_BEEF, "R7", "refetched written word", longint'(r), 32'hDEAD_BEEF);

    // R9: write miss allocates then merges
    do_acc(1'b1, 10 * BW * 4 + 4, 32'h1234_5678, "R9", h, r);
    chk(!h, "R9", "write miss detected", longint'(h), 0);
    do_acc(1'b0, 10 * BW * 4, '0, "R9", h, r);
    chk(h && r == pat(10 * BW), "R9", "untouched word from memory", longint'(r), longint'(pat(10 * BW)));
    do_acc(1'b0, 10 * BW * 4 + 4, '0, "R9", h, r);
    chk(r == 32'h1234_5678, "R9", "merged word", longint'(r), 32'h1234_5678);

    // R6: write hit refreshes recency in set 1
    do_acc(1'b0, 1 * BW * 4, '0, "R6", h, r);
    do_acc(1'b0, 3 * BW * 4, '0, "R6", h, r);
    do_acc(1'b1, 1 * BW * 4, 32'h0000_0A0A, "R6", h, r);
    do_acc(1'b0, 5 * BW * 4, '0, "R6", h, r);
    do_acc(1'b0, 1 * BW * 4, '0, "R6", h, r);
    chk(h, "R6", "write-touched way survives", longint'(h), 1);

    // R1: tag aliasing in one set (blocks 0 and 64 share set 0)
    do_acc(1'b1, 64 * BW * 4, 32'h5555_AAAA, "R1", h, r);
    do_acc(1'b0, 0, '0, "R1", h, r);
    do_acc(1'b0, 64 * BW * 4, '0, "R1", h, r);
    chk(r == 32'h5555_AAAA, "R1", "aliased tag data", longint'(r), 32'h5555_AAAA);

    // mixed pseudo-random traffic
    lcg = 12345;
    for (int i = 0; i < 400; i++) begin
      int b, w;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fff_ffff;
      b = (lcg >> 8) % 12;
      if (((lcg >> 4) % 16) == 0) b = 100 + b;
      w = (lcg >> 16) % BW;
      do_acc(((lcg >> 20) % 3) == 0, (b * BW + w) * 4, 32'(lcg), "R2", h, r);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule